// File: doc/BRIEF.md
# Cursor and Crosshair Overlay Generator

This block lays a hardware pointer over a video stream. It follows the horizontal and vertical sync inputs to know which pixel the display is on. For every clock it produces two overlay plane bits for each pixel slot in that clock. Depending on the multiplex setting, one clock carries one, four or five pixels. A colour stage further down the pipeline turns the two plane bits into a colour.

Two shapes can be drawn:
- A 64x64 bitmap cursor with two planes, held in an internal 512-word memory and loaded through a simple write port.
- A crosshair of selectable thickness. It is centred on the cursor and clipped to a programmable window.

A command input enables each shape and chooses whether the two merge by OR or by XOR. Cursor and window coordinates are given in the programmed coordinate space. The block adds a fixed pipeline offset to the horizontal coordinates, and that offset depends on the multiplex mode. It adds 32 lines to the vertical coordinates.

Top module: `ovl_cursor_gen`

## Requirements
- R1: After reset, all bits of `ovl_a_o` and `ovl_b_o` are zero, and both position counters are zero.
- R2: On each falling edge of `hsync_i`, the X counter X clears to 0. Y clears to 0 if `vsync_i` is low at that edge; otherwise Y increments by one. In every other clock, X advances by the number of active lanes. Lane k covers pixel X+k. The outputs are registered, so they appear one clock after the counter values they describe.
- R3: `cmd_i[3:2]` sets the number of active lanes: 00 gives 1, 01 gives 4, 10 gives 5, and 11 behaves exactly like 00. Lanes at or above the active count output 0 on both planes.
- R4: The cursor column is c = (X+k − cur_x − P) mod 4096, where P is 37 for mux code 00 or 11, 52 for 01 and 57 for 10. The cursor row is r = (Y − cur_y − 32) mod 4096. A pixel lies inside the cursor when c < 64 and r < 64. Outside that area the cursor contributes 0 to both planes.
- R5: Cursor pixel (c, r) reads memory word r*8 + c/8. Plane A is bit 15 − (c mod 8) and plane B is bit 7 − (c mod 8). The write port stores `bmp_data_i` at `bmp_addr_i` while `bmp_we_i` is high.
- R6: `cmd_i[6]` enables the cursor and `cmd_i[5]` enables the crosshair. When both bits are 0, every output bit is 0.
- R7: A crosshair pixel is set on both planes when three conditions hold:
  - It is inside the window: (X+k − win_x − P) mod 4096 < win_w and (Y − win_y − 32) mod 4096 < win_h.
  - The signed distance of c from 32, or of r from 32, is at most `cmd_i[1:0]`. This gives line widths of 1, 3, 5 and 7.
  - The crosshair is enabled.
- R8: If the window width or the window height is zero, no crosshair pixel is drawn.
- R9: `cmd_i[4]` = 1 merges the cursor and crosshair by OR on each plane. `cmd_i[4]` = 0 merges them by XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync; its falling edge starts a line |
| vsync_i | input | 1 | Vertical sync; low at a line start restarts the frame |
| cmd_i | input | 7 | Enables, merge mode, mux ratio and thickness |
| cur_x_i | input | 12 | Programmed cursor X |
| cur_y_i | input | 12 | Programmed cursor Y |
| win_x_i | input | 12 | Programmed crosshair window X |
| win_y_i | input | 12 | Programmed crosshair window Y |
| win_w_i | input | 12 | Crosshair window width |
| win_h_i | input | 12 | Crosshair window height |
| bmp_we_i | input | 1 | Bitmap memory write enable |
| bmp_addr_i | input | 9 | Bitmap memory word address |
| bmp_data_i | input | 16 | Bitmap word, plane A high byte |
| ovl_a_o | output | 5 | Plane A bit per pixel lane |
| ovl_b_o | output | 5 | Plane B bit per pixel lane |

## Verification
The assertions watch rules that hold on every clock:
- The X counter clears after a line start.
- Y restarts when the frame marker is present at a line start.
- Inactive lanes stay dark in the 1:1, reserved and 4:1 modes.
- The output is dark when both shapes are disabled.
- The output is dark when the window is empty and the cursor is off.

Only the scanned frames can show correct placement. These cover the bitmap bit order and word addressing, the mode-dependent offsets, the crosshair thickness and window clipping, and OR versus XOR merging. The bench compares every lane of every clock across whole frames with an independent pixel model.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int unsigned MAX_LANES = 5;
    localparam int unsigned CUR_DIM   = 64;
    localparam int unsigned ROW_WORDS = CUR_DIM / 8;
    localparam int unsigned RAM_WORDS = CUR_DIM * ROW_WORDS;
    localparam int unsigned RAM_AW    = $clog2(RAM_WORDS);
    localparam int unsigned CUR_AW    = $clog2(CUR_DIM);
    localparam int unsigned CENTRE    = CUR_DIM / 2;
    localparam int unsigned Y_BIAS    = 32;

    typedef enum logic [1:0] {
        MUX_ONE  = 2'b00,
        MUX_FOUR = 2'b01,
        MUX_FIVE = 2'b10,
        MUX_RSV  = 2'b11
    } mux_e;

    function automatic logic [2:0] lane_count(input logic [1:0] m);
        case (mux_e'(m))
            MUX_FOUR: return 3'd4;
            MUX_FIVE: return 3'd5;
            default:  return 3'd1;
        endcase
    endfunction

    function automatic logic [5:0] pipe_skew(input logic [1:0] m);
        case (mux_e'(m))
            MUX_FOUR: return 6'd52;
            MUX_FIVE: return 6'd57;
            default:  return 6'd37;
        endcase
    endfunction
endpackage

// File: rtl/ovl_timing.sv
module ovl_timing #(
    parameter int unsigned POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic [2:0]       step_i,
    output logic [POS_W-1:0] x_o,
    output logic [POS_W-1:0] y_o
);
    typedef struct packed {
        logic             hs;
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
    } tim_t;

    tim_t tim_d, tim_q;
    logic line_start;

    always_comb begin
        tim_d      = tim_q;
        tim_d.hs   = hsync_i;
        line_start = tim_q.hs && !hsync_i;
        if (line_start) begin
            tim_d.x = '0;
            tim_d.y = vsync_i ? tim_q.y + 1'b1 : '0;
        end else begin
            tim_d.x = tim_q.x + POS_W'(step_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign x_o = tim_q.x;
    assign y_o = tim_q.y;

    // R2: a line start clears the pixel counter
    p_xclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_q.hs && !hsync_i) |=> (x_o == '0));

    // R2: frame marker at a line start restarts the line count
    p_yclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_q.hs && !hsync_i && !vsync_i) |=> (y_o == '0));
endmodule

// File: rtl/ovl_bitmap.sv
module ovl_bitmap #(
    parameter int unsigned AW    = 9,
    parameter int unsigned PORTS = 5
) (
    input  logic                      clk,
    input  logic                      we_i,
    input  logic [AW-1:0]             waddr_i,
    input  logic [15:0]               wdata_i,
    input  logic [PORTS-1:0][AW-1:0]  raddr_i,
    output logic [PORTS-1:0][15:0]    rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [15:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rdata_o[p] = mem_q[raddr_i[p]];
    end
endmodule

// File: rtl/ovl_lane.sv
module ovl_lane
    import ovl_pkg::*;
#(
    parameter int unsigned POS_W = 12
) (
    input  logic [POS_W-1:0]  xpos_i,
    input  logic [POS_W-1:0]  ypos_i,
    input  logic [POS_W-1:0]  cur_x_i,
    input  logic [POS_W-1:0]  cur_y_i,
    input  logic [POS_W-1:0]  win_x_i,
    input  logic [POS_W-1:0]  win_y_i,
    input  logic [POS_W-1:0]  win_w_i,
    input  logic [POS_W-1:0]  win_h_i,
    input  logic [5:0]        skew_i,
    input  logic [1:0]        half_i,
    input  logic              cur_en_i,
    input  logic              xh_en_i,
    input  logic              or_mode_i,
    input  logic              active_i,
    output logic [RAM_AW-1:0] addr_o,
    input  logic [15:0]       word_i,
    output logic              pa_o,
    output logic              pb_o
);
    logic [POS_W-1:0] col, row, dcx, dcy, wxo, wyo;
    logic [2:0]       sel;
    logic             in_cur, in_win, near_x, near_y, xh, ca, cb;

    always_comb begin
        col    = xpos_i - cur_x_i - POS_W'(skew_i);
        row    = ypos_i - cur_y_i - POS_W'(Y_BIAS);
        in_cur = (col < POS_W'(CUR_DIM)) && (row < POS_W'(CUR_DIM));
        addr_o = {row[CUR_AW-1:0], col[CUR_AW-1:3]};
        sel    = 3'd7 - col[2:0];
        ca     = cur_en_i && in_cur && word_i[{1'b1, sel}];
        cb     = cur_en_i && in_cur && word_i[{1'b0, sel}];

        dcx    = col - POS_W'(CENTRE);
        dcy    = row - POS_W'(CENTRE);
        near_x = (dcx <= POS_W'(half_i)) || (('0 - dcx) <= POS_W'(half_i));
        near_y = (dcy <= POS_W'(half_i)) || (('0 - dcy) <= POS_W'(half_i));
        wxo    = xpos_i - win_x_i - POS_W'(skew_i);
        wyo    = ypos_i - win_y_i - POS_W'(Y_BIAS);
        in_win = (wxo < win_w_i) && (wyo < win_h_i);
        xh     = xh_en_i && in_win && (near_x || near_y);

        pa_o   = active_i && (or_mode_i ? (ca | xh) : (ca ^ xh));
        pb_o   = active_i && (or_mode_i ? (cb | xh) : (cb ^ xh));
    end
endmodule

// File: rtl/ovl_cursor_gen.sv
module ovl_cursor_gen
    import ovl_pkg::*;
#(
    parameter int unsigned POS_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsync_i,
    input  logic                 vsync_i,
    input  logic [6:0]           cmd_i,
    input  logic [POS_W-1:0]     cur_x_i,
    input  logic [POS_W-1:0]     cur_y_i,
    input  logic [POS_W-1:0]     win_x_i,
    input  logic [POS_W-1:0]     win_y_i,
    input  logic [POS_W-1:0]     win_w_i,
    input  logic [POS_W-1:0]     win_h_i,
    input  logic                 bmp_we_i,
    input  logic [RAM_AW-1:0]    bmp_addr_i,
    input  logic [15:0]          bmp_data_i,
    output logic [MAX_LANES-1:0] ovl_a_o,
    output logic [MAX_LANES-1:0] ovl_b_o
);
    typedef struct packed {
        logic [MAX_LANES-1:0] a;
        logic [MAX_LANES-1:0] b;
    } out_t;

    out_t                              out_d, out_q;
    logic [POS_W-1:0]                  x_q, y_q;
    logic [2:0]                        lanes;
    logic [5:0]                        skew;
    logic [MAX_LANES-1:0][RAM_AW-1:0]  rd_addr;
    logic [MAX_LANES-1:0][15:0]        rd_data;
    logic [MAX_LANES-1:0]              pa, pb;

    assign lanes = lane_count(cmd_i[3:2]);
    assign skew  = pipe_skew(cmd_i[3:2]);

    ovl_timing #(.POS_W(POS_W)) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync_i (hsync_i),
        .vsync_i (vsync_i),
        .step_i  (lanes),
        .x_o     (x_q),
        .y_o     (y_q)
    );

    ovl_bitmap #(.AW(RAM_AW), .PORTS(MAX_LANES)) u_bitmap (
        .clk     (clk),
        .we_i    (bmp_we_i),
        .waddr_i (bmp_addr_i),
        .wdata_i (bmp_data_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        ovl_lane #(.POS_W(POS_W)) u_lane (
            .xpos_i    (x_q + POS_W'(k)),
            .ypos_i    (y_q),
            .cur_x_i   (cur_x_i),
            .cur_y_i   (cur_y_i),
            .win_x_i   (win_x_i),
            .win_y_i   (win_y_i),
            .win_w_i   (win_w_i),
            .win_h_i   (win_h_i),
            .skew_i    (skew),
            .half_i    (cmd_i[1:0]),
            .cur_en_i  (cmd_i[6]),
            .xh_en_i   (cmd_i[5]),
            .or_mode_i (cmd_i[4]),
            .active_i  (3'(k) < lanes),
            .addr_o    (rd_addr[k]),
            .word_i    (rd_data[k]),
            .pa_o      (pa[k]),
            .pb_o      (pb[k])
        );
    end

    always_comb begin
        out_d   = out_q;
        out_d.a = pa;
        out_d.b = pb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ovl_a_o = out_q.a;
    assign ovl_b_o = out_q.b;

    // R3: single-lane modes (00 and reserved 11) leave upper lanes dark
    p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i[3:2] == 2'b00 || cmd_i[3:2] == 2'b11)
        |=> (ovl_a_o[MAX_LANES-1:1] == '0 && ovl_b_o[MAX_LANES-1:1] == '0));

    // R3: four-lane mode leaves the fifth lane dark
    p_four_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i[3:2] == 2'b01) |=> (ovl_a_o[4] == 1'b0 && ovl_b_o[4] == 1'b0));

    // R6: both shapes disabled gives a dark overlay
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i[6] && !cmd_i[5]) |=> (ovl_a_o == '0 && ovl_b_o == '0));

    // R8: empty window with cursor off gives a dark overlay
    p_nowin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i[6] && (win_w_i == '0 || win_h_i == '0))
        |=> (ovl_a_o == '0 && ovl_b_o == '0));
endmodule

// File: tb/ovl_cursor_gen_tb.sv
`timescale 1ns/1ps
module ovl_cursor_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b1;
    logic        vsync = 1'b1;
    logic [6:0]  cmd = '0;
    logic [11:0] cx = '0, cy = '0, wx = '0, wy = '0, ww = '0, wh = '0;
    logic        we = 1'b0;
    logic [8:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic [4:0]  oa, ob;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int line_y = 0;
    bit done   = 1'b0;

    typedef struct {
        int         at;
        logic [4:0] a;
        logic [4:0] b;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ovl_cursor_gen u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .cmd_i(cmd), .cur_x_i(cx), .cur_y_i(cy), .win_x_i(wx), .win_y_i(wy),
        .win_w_i(ww), .win_h_i(wh), .bmp_we_i(we), .bmp_addr_i(waddr),
        .bmp_data_i(wdata), .ovl_a_o(oa), .ovl_b_o(ob)
    );

    function automatic logic [15:0] pat(int w);
        logic [7:0] hi, lo;
        hi = 8'(w * 7 + 3) ^ 8'(w >> 1);
        lo = 8'(w * 13) ^ 8'h3C;
        return {hi, lo};
    endfunction

    function automatic int wrap(int v);
        return ((v % 4096) + 4096) % 4096;
    endfunction

    function automatic int sdist(int v);
        int m;
        m = wrap(v);
        if (m >= 2048) m = 4096 - m;
        return m;
    endfunction

    // Independent pixel model: returns {A,B}
    function automatic logic [1:0] model(int xp, int yp);
        int skew, c, r, half, wxo, wyo;
        logic ca, cb, xh;
        logic [15:0] w;
        case (cmd[3:2])
            2'b01:   skew = 52;
            2'b10:   skew = 57;
            default: skew = 37;
        endcase
        c = wrap(xp - int'(cx) - skew);
        r = wrap(yp - int'(cy) - 32);
        ca = 1'b0; cb = 1'b0; xh = 1'b0;
        if (cmd[6] && c < 64 && r < 64) begin
            w  = pat(r * 8 + c / 8);
            ca = w[15 - (c % 8)];
            cb = w[7 - (c % 8)];
        end
        half = int'(cmd[1:0]);
        wxo  = wrap(xp - int'(wx) - skew);
        wyo  = wrap(yp - int'(wy) - 32);
        if (cmd[5] && wxo < int'(ww) && wyo < int'(wh))
            xh = (sdist(c - 32) <= half) || (sdist(r - 32) <= half);
        if (cmd[4]) return {ca | xh, cb | xh};
        else        return {ca ^ xh, cb ^ xh};
    endfunction

    function automatic int nlanes();
        case (cmd[3:2])
            2'b01:   return 4;
            2'b10:   return 5;
            default: return 1;
        endcase
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin
        if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
            item_t it;
            it = exp_q.pop_front();
            n_run++;
            if (oa !== it.a || ob !== it.b) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got a=%b b=%b exp a=%b b=%b",
                         it.tag, cyc, oa, ob, it.a, it.b);
            end
        end
    end

    // Driver: one line, frame restart when first is set
    task automatic scan_line(bit first, int n, string tag);
        int c0, lanes;
        item_t it;
        @(negedge clk);
        hsync = 1'b1;
        vsync = first ? 1'b0 : 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        @(negedge clk);
        vsync = 1'b1;
        c0 = cyc;
        line_y = first ? 0 : line_y + 1;
        lanes = nlanes();
        for (int i = 1; i <= n; i++) begin
            logic [1:0] p;
            it.at = c0 + i;
            it.a  = '0;
            it.b  = '0;
            for (int k = 0; k < lanes; k++) begin
                p = model(lanes * (i - 1) + k, line_y);
                it.a[k] = p[1];
                it.b[k] = p[0];
            end
            it.tag = tag;
            exp_q.push_back(it);
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic scan_frame(int lines, int n, string tag);
        scan_line(1'b1, n, tag);
        for (int l = 1; l < lines; l++) scan_line(1'b0, n, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_run++;
        if (oa !== 5'b0 || ob !== 5'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got a=%b b=%b exp a=00000 b=00000", oa, ob);
        end
        rst_n = 1'b1;

        // R5: load bitmap through the write port
        for (int w = 0; w < 512; w++) begin
            @(negedge clk);
            we = 1'b1; waddr = 9'(w); wdata = pat(w);
        end
        @(negedge clk);
        we = 1'b0;

        // R4 R5 R2: cursor only, 1:1, XOR
        cmd = 7'h40; cx = 12'd0; cy = 12'd4064;
        scan_frame(66, 110, "R2/R4/R5 cursor 1:1");

        // R3 R9: cursor only, 4:1, OR, unaligned X
        cmd = 7'h54; cx = 12'd5;
        scan_frame(66, 32, "R3/R4/R9 cursor 4:1");

        // R7 R9: cursor + crosshair XOR, 5:1, thickness 3
        cmd = 7'h69; cx = 12'd3; wx = 12'd4076; ww = 12'd90;
        wy = 12'd4069; wh = 12'd40;
        scan_frame(66, 27, "R3/R7/R9 xor 5:1");

        // R3 R7 R9: reserved mux behaves 1:1, OR, thickness 7
        cmd = 7'h7F; cx = 12'd10; wx = 12'd0; ww = 12'd200;
        wy = 12'd4064; wh = 12'd66;
        scan_frame(66, 120, "R3/R7/R9 reserved mux");

        // R7: crosshair only, thickness 1, 4:1
        cmd = 7'h24;
        scan_frame(66, 32, "R7 thin crosshair");

        // R8: zero-width and zero-height windows
        cmd = 7'h28; ww = 12'd0; wh = 12'd50;
        scan_frame(40, 27, "R8 zero width");
        ww = 12'd50; wh = 12'd0;
        scan_frame(40, 27, "R8 zero height");

        // R6: both shapes disabled
        cmd = 7'h08; ww = 12'd200; wh = 12'd66;
        scan_frame(40, 27, "R6 all off");

        repeat (4) @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end
endmodule